// File: doc/BRIEF.md
# High/Low Phase Programmable Clock Channel

This block produces one derived clock from a parent clock. A control word sets the length of the output's high phase and the length of its low phase separately, each counted in parent cycles. Odd division ratios and duty cycles other than 50% are therefore possible. When the divide-enable bit is clear the parent clock is passed through unchanged. An output-enable bit in a second register gates the result. A build parameter can remove that gate, and the channel is then always enabled.

Software programs the channel through a small synchronous register port that has an address, write data, a write strobe and combinational read data. Every change is timed so that the output never shows a shortened pulse. New phase lengths are picked up only when an output period ends. Switching between pass-through and divided mode, and turning the gate on or off, both happen only while the selected clock source is low.

Top module: `hl_clkdiv_chan`

## Requirements
- R1: With the divide-enable bit clear and the channel enabled, `clk_out` follows `clk`: it is high while `clk` is high and low while `clk` is low.
- R2: With divide-enable set, each high phase of `clk_out` lasts (high field + 1) parent cycles.
- R3: With divide-enable set, each low phase of `clk_out` lasts (low field + 1) parent cycles, so a period is (high + 1) + (low + 1) cycles.
- R4: Both fields zero gives the smallest ratio, divide by 2. Both fields equal to N/2 − 1 gives an even ratio N at 50% duty.
- R5: The control register is at address 0 and reads back the whole word last written. The high field is `wdata[HI_LSB +: HI_W]`, the low field is `wdata[LO_LSB +: LO_W]` and divide-enable is bit `EN_BIT`. The gate register is at address 1 and holds only bit `GATE_BIT`; all its other bits read 0. Addresses 2 and 3 read 0.
- R6: With a gate present, setting the gate bit lets the clock out and clearing it holds `clk_out` low.
- R7: With `HAS_GATE` = 0 the channel is always enabled. Gate writes do not change `clk_out`, and the gate register reads 0.
- R8: Field values written during a period take effect only from the next period. The period in progress completes with its old lengths.
- R9: The mode select and the gate change only while the selected source is low. A high phase in progress when divide-enable or the gate is cleared runs to its full length.
- R10: Synchronous active-high reset clears the control word and the gate bit. The channel then sits in pass-through with the gate closed, and `clk_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock; also clocks the register port |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register address (0 control, 1 gate) |
| wdata | input | DW | Write data |
| we | input | 1 | Write strobe, sampled on the rising edge of `clk` |
| rdata | output | DW | Read data for `addr`, combinational |
| clk_out | output | 1 | Derived, gated output clock |

## Verification
The bench builds two copies on shared register inputs. Both use 4-bit high and low fields at bits 3:0 and 7:4, divide-enable at bit 8, a 16-bit data word and the gate at bit 2. One copy has the gate and the other is built without it. The narrow fields make the largest ratio (16 high plus 16 low cycles) cheap to reach, together with the divide-by-2 floor and odd splits. The gateless copy runs next to the gated one, so a gate write can be shown to affect one output and leave the other alone.

// File: rtl/hlcd_pkg.sv
package hlcd_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_GATE = 2'd1,
        REG_RSV2 = 2'd2,
        REG_RSV3 = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // widest of two field widths, plus headroom for a count of length+1
    function automatic int unsigned run_width(input int unsigned a, input int unsigned b);
        return ((a > b) ? a : b) + 2;
    endfunction

endpackage

// File: rtl/hlcd_regs.sv
module hlcd_regs
    import hlcd_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned HI_LSB   = 0,
    parameter int unsigned HI_W     = 8,
    parameter int unsigned LO_LSB   = 8,
    parameter int unsigned LO_W     = 8,
    parameter int unsigned EN_BIT   = 16,
    parameter int unsigned GATE_BIT = 0,
    parameter bit          HAS_GATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              we,
    output logic [DW-1:0]     rdata,
    output logic              div_en,
    output logic [HI_W-1:0]   hi_cnt,
    output logic [LO_W-1:0]   lo_cnt,
    output logic              gate_en
);

    logic [DW-1:0] ctrl_q;
    logic          gate_bit;
    reg_sel_e      sel;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we && sel == REG_CTRL) begin
            ctrl_q <= wdata;
        end
    end

    generate
        if (HAS_GATE) begin : g_gate
            logic gate_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    gate_q <= 1'b0;
                end else if (we && sel == REG_GATE) begin
                    gate_q <= wdata[GATE_BIT];
                end
            end
            assign gate_bit = gate_q;
            assign gate_en  = gate_q;
        end else begin : g_nogate
            assign gate_bit = 1'b0;
            assign gate_en  = 1'b1;
        end
    endgenerate

    assign div_en = ctrl_q[EN_BIT];
    assign hi_cnt = ctrl_q[HI_LSB +: HI_W];
    assign lo_cnt = ctrl_q[LO_LSB +: LO_W];

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_CTRL: rdata = ctrl_q;
            REG_GATE: rdata[GATE_BIT] = gate_bit;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/hlcd_phase.sv
module hlcd_phase
    import hlcd_pkg::*;
#(
    parameter int unsigned HI_W = 8,
    parameter int unsigned LO_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_div,
    input  logic [HI_W-1:0] hi_cnt,
    input  logic [LO_W-1:0] lo_cnt,
    output phase_e          phase,
    output logic [HI_W-1:0] hi_sh,
    output logic [LO_W-1:0] lo_sh
);

    localparam int unsigned CW = (HI_W > LO_W) ? HI_W : LO_W;

    logic [CW-1:0] cnt;
    logic          hi_done;
    logic          lo_done;

    assign hi_done = (cnt == CW'(hi_sh));
    assign lo_done = (cnt == CW'(lo_sh));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LOW;
            cnt   <= '0;
            hi_sh <= '0;
            lo_sh <= '0;
        end else if (!sel_div) begin
            // idle: park at the end of a low phase so the first active edge starts high
            phase <= PH_LOW;
            cnt   <= CW'(lo_cnt);
            hi_sh <= hi_cnt;
            lo_sh <= lo_cnt;
        end else if (phase == PH_LOW) begin
            if (lo_done) begin
                phase <= PH_HIGH;
                cnt   <= '0;
                hi_sh <= hi_cnt;
                lo_sh <= lo_cnt;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (hi_done) begin
                phase <= PH_LOW;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hlcd_outsel.sv
module hlcd_outsel
    import hlcd_pkg::*;
#(
    parameter bit HAS_GATE = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   div_en,
    input  logic   gate_en,
    input  phase_e phase,
    output logic   sel_div,
    output logic   gate_q,
    output logic   clk_out
);

    logic div_lvl;

    assign div_lvl = (phase == PH_HIGH);

    // updated while clk is low; the divided source must also be low
    always_ff @(negedge clk) begin
        if (rst) begin
            sel_div <= 1'b0;
        end else if (!div_lvl) begin
            sel_div <= div_en;
        end
    end

    generate
        if (HAS_GATE) begin : g_gate
            always_ff @(negedge clk) begin
                if (rst) begin
                    gate_q <= 1'b0;
                end else if (!sel_div || !div_lvl) begin
                    gate_q <= gate_en;
                end
            end
        end else begin : g_open
            assign gate_q = 1'b1;
        end
    endgenerate

    assign clk_out = gate_q & (sel_div ? div_lvl : clk);

endmodule

// File: rtl/hl_clkdiv_chan.sv
module hl_clkdiv_chan
    import hlcd_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned HI_LSB   = 0,
    parameter int unsigned HI_W     = 8,
    parameter int unsigned LO_LSB   = 8,
    parameter int unsigned LO_W     = 8,
    parameter int unsigned EN_BIT   = 16,
    parameter int unsigned GATE_BIT = 0,
    parameter bit          HAS_GATE = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    output logic          clk_out
);

    logic            cfg_en;
    logic [HI_W-1:0] cfg_hi;
    logic [LO_W-1:0] cfg_lo;
    logic            cfg_gate;
    logic            sel_div;
    logic            gate_q;
    phase_e          phase;
    logic [HI_W-1:0] hi_sh;
    logic [LO_W-1:0] lo_sh;

    hlcd_regs #(
        .DW(DW), .HI_LSB(HI_LSB), .HI_W(HI_W), .LO_LSB(LO_LSB), .LO_W(LO_W),
        .EN_BIT(EN_BIT), .GATE_BIT(GATE_BIT), .HAS_GATE(HAS_GATE)
    ) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
        .div_en(cfg_en), .hi_cnt(cfg_hi), .lo_cnt(cfg_lo), .gate_en(cfg_gate)
    );

    hlcd_phase #(.HI_W(HI_W), .LO_W(LO_W)) u_phase (
        .clk(clk), .rst(rst), .sel_div(sel_div), .hi_cnt(cfg_hi), .lo_cnt(cfg_lo),
        .phase(phase), .hi_sh(hi_sh), .lo_sh(lo_sh)
    );

    hlcd_outsel #(.HAS_GATE(HAS_GATE)) u_outsel (
        .clk(clk), .rst(rst), .div_en(cfg_en), .gate_en(cfg_gate), .phase(phase),
        .sel_div(sel_div), .gate_q(gate_q), .clk_out(clk_out)
    );

endmodule

// File: rtl/hlcd_chk.sv
module hlcd_chk
    import hlcd_pkg::*;
#(
    parameter int unsigned HI_W = 8,
    parameter int unsigned LO_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_en,
    input logic            cfg_gate,
    input logic            sel_div,
    input logic            gate_q,
    input phase_e          phase,
    input logic [HI_W-1:0] hi_sh,
    input logic            hi_en_gate
);

    localparam int unsigned RW = run_width(HI_W, LO_W);

    logic          div_lvl;
    logic          prev_lvl;
    logic [RW-1:0] run_cnt;

    assign div_lvl = (phase == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= 1'b0;
            run_cnt  <= '0;
        end else begin
            prev_lvl <= div_lvl;
            if (div_lvl != prev_lvl)  run_cnt <= RW'(1);
            else if (~&run_cnt)       run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2: a finished high phase lasted high field + 1 cycles
    p_high_len_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_div && prev_lvl && !div_lvl) |-> (run_cnt == RW'(hi_sh) + RW'(1)));

    // R9: mode select moves only while the divided level is low
    p_mode_switch_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_div) |-> !div_lvl);

    // R9: gate moves only while the selected source is low
    p_gate_switch_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate_q) |-> (!$past(sel_div) || !div_lvl));

    // R1: in pass-through the divider stays parked low
    p_bypass_parked_r1: assert property (@(posedge clk) disable iff (rst)
        !sel_div |=> !div_lvl);

    // R10: reset leaves pass-through, gate closed, divider low
    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (!cfg_en && !sel_div && !div_lvl && (!hi_en_gate || !cfg_gate)));

endmodule

bind hl_clkdiv_chan hlcd_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_gate(cfg_gate), .sel_div(sel_div),
    .gate_q(gate_q), .phase(phase), .hi_sh(hi_sh), .hi_en_gate(HAS_GATE)
);

// File: tb/test_hl_clkdiv_chan.sv
`timescale 1ns/1ps
module test_hl_clkdiv_chan;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          we = 1'b0;
    logic [DW-1:0] rdata, rdata_ng;
    logic          clk_out, clk_out_ng;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hl_clkdiv_chan #(.DW(DW), .HI_LSB(0), .HI_W(4), .LO_LSB(4), .LO_W(4),
        .EN_BIT(8), .GATE_BIT(2), .HAS_GATE(1'b1)) i_hl_clkdiv_chan (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .clk_out(clk_out));

    hl_clkdiv_chan #(.DW(DW), .HI_LSB(0), .HI_W(4), .LO_LSB(4), .LO_W(4),
        .EN_BIT(8), .GATE_BIT(2), .HAS_GATE(1'b0)) i_hl_clkdiv_chan_ng (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata_ng), .clk_out(clk_out_ng));

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ctrl(input bit en, input int h, input int l);
        return DW'((int'(en) << 8) | (l << 4) | h);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic smp(input bit ng, output bit v);
        @(negedge clk); #1;
        v = ng ? clk_out_ng : clk_out;
    endtask

    task automatic wait_rise(input bit ng, output bit ok);
        bit p, c;
        ok = 1'b0;
        smp(ng, p);
        for (int i = 0; i < 200; i++) begin
            smp(ng, c);
            if (!p && c) begin ok = 1'b1; break; end
            p = c;
        end
    endtask

    task automatic run_len(input bit ng, input bit val, input int start, output int n);
        bit v;
        n = start;
        for (int i = 0; i < 100; i++) begin
            smp(ng, v);
            if (v != val) break;
            n++;
        end
    endtask

    task automatic measure(input bit ng, input int h, input int l, input string req);
        bit ok; int nh, nl, nh2;
        wait_rise(ng, ok);
        chk(ok, req, ok, 1);
        run_len(ng, 1'b1, 1, nh);
        run_len(ng, 1'b0, 1, nl);
        run_len(ng, 1'b1, 1, nh2);
        chk(nh == h + 1, req, nh, h + 1);
        chk(nl == l + 1, req, nl, l + 1);
        chk(nh2 == h + 1, req, nh2, h + 1);
    endtask

    task automatic bypass_chk(input bit ng, input bit exp_hi, input string req);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            chk((ng ? clk_out_ng : clk_out) == exp_hi, req, ng ? clk_out_ng : clk_out, exp_hi);
            @(negedge clk); #1;
            chk((ng ? clk_out_ng : clk_out) == 1'b0, req, ng ? clk_out_ng : clk_out, 0);
        end
    endtask

    // R10 reset state, R7 gateless channel passes the clock
    task automatic t_reset();
        addr = 2'd0; #1;
        chk(rdata == '0, "R10 ctrl", rdata, 0);
        addr = 2'd1; #1;
        chk(rdata == '0, "R10 gate", rdata, 0);
        bypass_chk(1'b0, 1'b0, "R10 out low");
        bypass_chk(1'b1, 1'b1, "R7 no gate open");
    endtask

    // R5 register layout and readback, R7 gate reads 0 without gate
    task automatic t_regs();
        wr(2'd0, 16'hA5F3);
        addr = 2'd0; #1;
        chk(rdata == 16'hA5F3, "R5 ctrl readback", rdata, 16'hA5F3);
        wr(2'd1, 16'hFFFF);
        addr = 2'd1; #1;
        chk(rdata == 16'h0004, "R5 gate readback", rdata, 16'h0004);
        chk(rdata_ng == 16'h0000, "R7 gate reads 0", rdata_ng, 0);
        wr(2'd2, 16'h1234);
        addr = 2'd2; #1;
        chk(rdata == '0, "R5 reserved", rdata, 0);
        wr(2'd0, '0);
        wr(2'd1, '0);
    endtask

    // R1 pass-through, R6 gate on/off, R7 gate writes ignored
    task automatic t_bypass();
        wr(2'd1, 16'h0004);
        repeat (2) @(posedge clk); #1;
        bypass_chk(1'b0, 1'b1, "R1 bypass");
        wr(2'd1, 16'h0000);
        repeat (2) @(posedge clk); #1;
        bypass_chk(1'b0, 1'b0, "R6 gate off");
        bypass_chk(1'b1, 1'b1, "R7 gate write ignored");
    endtask

    task automatic t_div(input int h, input int l, input string req);
        wr(2'd0, ctrl(1'b1, h, l));
        measure(1'b0, h, l, req);
        measure(1'b1, h, l, req);
    endtask

    // R8 new fields only from the next period
    task automatic t_update();
        bit ok; int n;
        wr(2'd0, ctrl(1'b1, 3, 2));
        wait_rise(1'b0, ok);
        wait_rise(1'b0, ok);
        chk(ok, "R8 start", ok, 1);
        wr(2'd0, ctrl(1'b1, 0, 0));
        run_len(1'b0, 1'b1, 1, n);
        chk(n == 4, "R8 old high kept", n, 4);
        run_len(1'b0, 1'b0, 1, n);
        chk(n == 3, "R8 old low kept", n, 3);
        run_len(1'b0, 1'b1, 1, n);
        chk(n == 1, "R8 new high", n, 1);
        run_len(1'b0, 1'b0, 1, n);
        chk(n == 1, "R8 new low", n, 1);
    endtask

    // R9 gate off and divider off both let the high phase finish
    task automatic t_switch();
        bit ok, v; int n;
        wr(2'd1, 16'h0004);
        wr(2'd0, ctrl(1'b1, 2, 2));
        wait_rise(1'b0, ok);
        wr(2'd1, 16'h0000);
        run_len(1'b0, 1'b1, 1, n);
        chk(n == 3, "R9 gate off completes high", n, 3);
        for (int i = 0; i < 10; i++) begin
            smp(1'b0, v);
            chk(v == 1'b0, "R9 gate stays off", v, 0);
        end
        measure(1'b1, 2, 2, "R7 gateless keeps running");
        wr(2'd1, 16'h0004);
        wr(2'd0, ctrl(1'b1, 3, 3));
        wait_rise(1'b0, ok);
        wr(2'd0, ctrl(1'b0, 3, 3));
        run_len(1'b0, 1'b1, 1, n);
        chk(n == 4, "R9 disable completes high", n, 4);
        repeat (2) @(posedge clk); #1;
        bypass_chk(1'b0, 1'b1, "R9 back to bypass");
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs();
        t_bypass();
        wr(2'd1, 16'h0004);
        t_div(0, 0, "R4 min divide by 2");
        t_div(2, 1, "R2 R3 odd split");
        t_div(3, 3, "R4 even 50pct");
        t_div(0, 5, "R3 short high long low");
        t_div(15, 15, "R2 R3 max fields");
        t_update();
        t_switch();
        report();
        $finish;
    end

endmodule